// File: doc/BRIEF.md
# Serial transceiver with frame-exact idle reporting

This block is an asynchronous serial transmitter and receiver pair sharing one frame configuration. A frame carries eight data bits, least significant first, between a low start bit and one or two high stop bits. An even or odd parity bit may sit between the data and the stop bits. Each bit lasts a fixed number of clock cycles, set by a parameter. The transmitter takes bytes over a valid/ready handshake. The receiver hands each byte out with a one-cycle valid pulse and a framing-error flag.

Three status outputs describe line activity with frame-exact timing. The receiver-idle flag stays low from the detected start edge until the whole stop period has passed. The transmitter-idle flag stays low until the last stop bit has been fully driven. A transmit-disable input lets the current character finish. Once the transmitter is fully quiet, a separate disabled-status flag rises, so software can shut the line down cleanly. None of these flags feeds back into how frames are sent or received.

Top module: `uart_idle_top`

## Requirements
- R1: After reset `txd_o` is 1, `tx_idle_o` and `rx_idle_o` are 1, `tx_ready_o` is 1, and `tx_dis_stat_o`, `par_err_o` and `rx_valid_o` are 0.
- R2: A transmitted frame has the following bit slots, each lasting CLKS_PER_BIT cycles: a start bit at 0, then data bits 0..7 in that order, then the parity bit if enabled, then the stop bit(s) at 1.
- R3: With `stop2_i`=0 the frame has one stop bit, and with `stop2_i`=1 it has two. The frame length F is CLKS_PER_BIT*(1+8+p+s), where p is 1 when parity is on and s is the stop count.
- R4: With `par_en_i`=1 the parity bit equals XOR of the data bits when `par_odd_i`=0, and its inverse when `par_odd_i`=1.
- R5: `tx_idle_o` falls on the clock edge that accepts a byte and stays low for exactly F cycles. `txd_o` is low in the first of those cycles.
- R6: `rx_idle_o` falls on the third clock edge after the line falls, and stays low for exactly F cycles, which covers the full stop period.
- R7: The receiver pulses `rx_valid_o` for one cycle at the centre of the first stop bit. At that moment `rx_data_o` holds the byte, and `rx_frm_err_o` is 1 exactly when that stop sample is low.
- R8: A received parity bit that does not match sets `par_err_o`. The flag holds until a cycle with `par_err_clr_i`=1, after which it reads 0.
- R9: `tx_ready_o` is 1 only while the transmitter is idle and `tx_dis_i` is 0. A `tx_valid_i` offered while disabled is not taken, and the line stays high.
- R10: Raising `tx_dis_i` during a frame does not alter that frame. `tx_dis_stat_o` stays 0 until `tx_idle_o` has risen and rises one clock later. It returns to 0 on the clock after `tx_dis_i` is cleared.
- R11: If the line goes low for less than half a bit, the receiver returns to idle after half a bit and delivers no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop2_i | input | 1 | 0: one stop bit, 1: two stop bits |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 0: even parity, 1: odd parity |
| tx_dis_i | input | 1 | Transmit disable request |
| tx_data_i | input | DATA_W | Byte to send |
| tx_valid_i | input | 1 | Byte offered |
| tx_ready_o | output | 1 | Byte accepted this cycle when valid |
| txd_o | output | 1 | Serial output |
| tx_idle_o | output | 1 | Transmitter fully idle |
| tx_dis_stat_o | output | 1 | Transmitter disabled and quiet |
| rxd_i | input | 1 | Serial input |
| rx_data_o | output | DATA_W | Received byte |
| rx_valid_o | output | 1 | One-cycle pulse with a received byte |
| rx_frm_err_o | output | 1 | First stop bit sampled low |
| par_err_clr_i | input | 1 | Clears the parity-error flag |
| par_err_o | output | 1 | Sticky parity mismatch flag |
| rx_idle_o | output | 1 | Receiver idle |

## Verification
The bench builds the block with CLKS_PER_BIT=8 and DATA_W=8. With these values a frame lasts 80 to 96 cycles, so all four combinations of parity and stop length fit in a short run. The same values also leave room for a disable issued in the middle of a frame, for injected framing and parity faults, and for a sub-half-bit glitch. Eight cycles per bit give an even half-bit of four, so the idle windows of both directions can be checked against F to the exact cycle.

// File: rtl/uart_idle_pkg.sv
package uart_idle_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_TAIL
  } ser_st_e;
endpackage

// File: rtl/uart_idle_tx.sv
module uart_idle_tx
  import uart_idle_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int DATA_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stop2_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              tx_dis_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              txd_o,
  output logic              tx_idle_o,
  output logic              tx_dis_stat_o
);
  localparam int CW = $clog2(CLKS_PER_BIT);
  localparam int IW = $clog2(DATA_W);
  localparam logic [CW-1:0] BIT_LAST = CW'(CLKS_PER_BIT - 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(DATA_W - 1);

  ser_st_e           st_q;
  logic [CW-1:0]     cnt_q;
  logic [IW-1:0]     idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              par_q, pen_q, two_q, dis_q;
  logic              bit_end;

  assign bit_end    = (cnt_q == BIT_LAST);
  assign tx_ready_o = (st_q == ST_IDLE) && !tx_dis_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      par_q <= 1'b0;
      pen_q <= 1'b0;
      two_q <= 1'b0;
      dis_q <= 1'b0;
    end else begin
      dis_q <= (st_q == ST_IDLE) && tx_dis_i;
      case (st_q)
        ST_IDLE: begin
          if (tx_valid_i && tx_ready_o) begin
            sh_q  <= tx_data_i;
            par_q <= (^tx_data_i) ^ par_odd_i;
            pen_q <= par_en_i;
            two_q <= stop2_i;
            cnt_q <= '0;
            idx_q <= '0;
            st_q  <= ST_START;
          end
        end
        ST_START: begin
          if (bit_end) begin
            cnt_q <= '0;
            st_q  <= ST_DATA;
          end else cnt_q <= cnt_q + CW'(1);
        end
        ST_DATA: begin
          if (bit_end) begin
            cnt_q <= '0;
            sh_q  <= sh_q >> 1;
            if (idx_q == IDX_LAST) begin
              idx_q <= '0;
              st_q  <= pen_q ? ST_PAR : ST_STOP;
            end else idx_q <= idx_q + IW'(1);
          end else cnt_q <= cnt_q + CW'(1);
        end
        ST_PAR: begin
          if (bit_end) begin
            cnt_q <= '0;
            st_q  <= ST_STOP;
          end else cnt_q <= cnt_q + CW'(1);
        end
        ST_STOP: begin
          // idx_q counts stop bits here
          if (bit_end) begin
            cnt_q <= '0;
            if (two_q && idx_q == '0) idx_q <= IW'(1);
            else begin
              idx_q <= '0;
              st_q  <= ST_IDLE;
            end
          end else cnt_q <= cnt_q + CW'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st_q)
      ST_START: txd_o = 1'b0;
      ST_DATA:  txd_o = sh_q[0];
      ST_PAR:   txd_o = par_q;
      default:  txd_o = 1'b1;
    endcase
  end

  assign tx_idle_o     = (st_q == ST_IDLE);
  assign tx_dis_stat_o = dis_q;
endmodule

// File: rtl/uart_idle_rx.sv
module uart_idle_rx
  import uart_idle_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int DATA_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stop2_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              rxd_i,
  input  logic              par_err_clr_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              rx_frm_err_o,
  output logic              par_err_o,
  output logic              rx_idle_o
);
  localparam int CW   = $clog2(2 * CLKS_PER_BIT);
  localparam int IW   = $clog2(DATA_W);
  localparam int HALF = CLKS_PER_BIT / 2;
  localparam int REST = CLKS_PER_BIT - HALF;
  localparam logic [CW-1:0] BIT_LAST  = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);
  localparam logic [CW-1:0] TAIL_ONE  = CW'(REST - 1);
  localparam logic [CW-1:0] TAIL_TWO  = CW'(REST + CLKS_PER_BIT - 1);
  localparam logic [IW-1:0] IDX_LAST  = IW'(DATA_W - 1);

  ser_st_e           st_q;
  logic [CW-1:0]     cnt_q;
  logic [IW-1:0]     idx_q;
  logic [DATA_W-1:0] sh_q, data_q;
  logic              s1_q, s2_q;
  logic              pen_q, odd_q, two_q;
  logic              vld_q, frm_q, perr_q;
  logic              bit_end, tail_end;

  assign bit_end  = (cnt_q == BIT_LAST);
  assign tail_end = (cnt_q == (two_q ? TAIL_TWO : TAIL_ONE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rxd_i;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      data_q <= '0;
      pen_q  <= 1'b0;
      odd_q  <= 1'b0;
      two_q  <= 1'b0;
      vld_q  <= 1'b0;
      frm_q  <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (par_err_clr_i) perr_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (!s2_q) begin
            pen_q <= par_en_i;
            odd_q <= par_odd_i;
            two_q <= stop2_i;
            cnt_q <= '0;
            st_q  <= ST_START;
          end
        end
        ST_START: begin
          // mid-bit recheck rejects short glitches
          if (cnt_q == HALF_LAST) begin
            cnt_q <= '0;
            idx_q <= '0;
            st_q  <= s2_q ? ST_IDLE : ST_DATA;
          end else cnt_q <= cnt_q + CW'(1);
        end
        ST_DATA: begin
          if (bit_end) begin
            cnt_q <= '0;
            sh_q  <= {s2_q, sh_q[DATA_W-1:1]};
            if (idx_q == IDX_LAST) st_q <= pen_q ? ST_PAR : ST_STOP;
            else idx_q <= idx_q + IW'(1);
          end else cnt_q <= cnt_q + CW'(1);
        end
        ST_PAR: begin
          if (bit_end) begin
            cnt_q <= '0;
            if (s2_q != ((^sh_q) ^ odd_q)) perr_q <= 1'b1;
            st_q <= ST_STOP;
          end else cnt_q <= cnt_q + CW'(1);
        end
        ST_STOP: begin
          if (bit_end) begin
            cnt_q  <= '0;
            data_q <= sh_q;
            vld_q  <= 1'b1;
            frm_q  <= !s2_q;
            st_q   <= ST_TAIL;
          end else cnt_q <= cnt_q + CW'(1);
        end
        ST_TAIL: begin
          // hold busy until the whole stop period has passed
          if (tail_end) begin
            cnt_q <= '0;
            st_q  <= ST_IDLE;
          end else cnt_q <= cnt_q + CW'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rx_data_o    = data_q;
  assign rx_valid_o   = vld_q;
  assign rx_frm_err_o = frm_q;
  assign par_err_o    = perr_q;
  assign rx_idle_o    = (st_q == ST_IDLE);
endmodule

// File: rtl/uart_idle_top.sv
module uart_idle_top #(
  parameter int CLKS_PER_BIT = 16,
  parameter int DATA_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stop2_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              tx_dis_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              txd_o,
  output logic              tx_idle_o,
  output logic              tx_dis_stat_o,
  input  logic              rxd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              rx_frm_err_o,
  input  logic              par_err_clr_i,
  output logic              par_err_o,
  output logic              rx_idle_o
);
  uart_idle_tx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_W(DATA_W)) u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stop2_i      (stop2_i),
    .par_en_i     (par_en_i),
    .par_odd_i    (par_odd_i),
    .tx_dis_i     (tx_dis_i),
    .tx_data_i    (tx_data_i),
    .tx_valid_i   (tx_valid_i),
    .tx_ready_o   (tx_ready_o),
    .txd_o        (txd_o),
    .tx_idle_o    (tx_idle_o),
    .tx_dis_stat_o(tx_dis_stat_o)
  );

  uart_idle_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_W(DATA_W)) u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stop2_i      (stop2_i),
    .par_en_i     (par_en_i),
    .par_odd_i    (par_odd_i),
    .rxd_i        (rxd_i),
    .par_err_clr_i(par_err_clr_i),
    .rx_data_o    (rx_data_o),
    .rx_valid_o   (rx_valid_o),
    .rx_frm_err_o (rx_frm_err_o),
    .par_err_o    (par_err_o),
    .rx_idle_o    (rx_idle_o)
  );
endmodule

// File: rtl/uart_idle_chk.sv
module uart_idle_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_dis_i,
  input logic tx_ready_o,
  input logic tx_idle_o,
  input logic tx_dis_stat_o,
  input logic txd_o,
  input logic rx_valid_o,
  input logic rx_idle_o,
  input logic par_err_o,
  input logic par_err_clr_i
);
  a_r9_ready_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> (tx_idle_o && !tx_dis_i));

  a_r2_idle_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_idle_o |-> txd_o);

  a_r5_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_idle_o) |-> !txd_o);

  a_r10_stat_needs_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_dis_stat_o |-> tx_idle_o);

  a_r10_stat_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_dis_stat_o) |-> ($past(tx_dis_i) && $past(tx_idle_o)));

  a_r10_stat_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_dis_i |=> !tx_dis_stat_o);

  a_r7_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  a_r6_valid_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> !rx_idle_o);

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_err_o && !par_err_clr_i) |=> par_err_o);

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_err_clr_i && $past(par_err_clr_i) && !rx_valid_o) |-> !par_err_o);
endmodule

bind uart_idle_top uart_idle_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tx_dis_i     (tx_dis_i),
  .tx_ready_o   (tx_ready_o),
  .tx_idle_o    (tx_idle_o),
  .tx_dis_stat_o(tx_dis_stat_o),
  .txd_o        (txd_o),
  .rx_valid_o   (rx_valid_o),
  .rx_idle_o    (rx_idle_o),
  .par_err_o    (par_err_o),
  .par_err_clr_i(par_err_clr_i)
);

// File: tb/tb_uart_idle_top.sv
`timescale 1ns/1ps
module tb_uart_idle_top;
  localparam int C  = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic          stop2, par_en, par_odd, tx_dis, tx_valid, tx_ready, txd;
  logic          tx_idle, tx_dis_stat, rxd, rx_valid, rx_frm, par_clr, par_err, rx_idle;
  logic [DW-1:0] tx_data, rx_data;
  logic          loop_sel, rx_drv;

  assign rxd = loop_sel ? txd : rx_drv;

  uart_idle_top #(.CLKS_PER_BIT(C), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .stop2_i(stop2), .par_en_i(par_en), .par_odd_i(par_odd),
    .tx_dis_i(tx_dis), .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .txd_o(txd), .tx_idle_o(tx_idle), .tx_dis_stat_o(tx_dis_stat), .rxd_i(rxd),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_frm_err_o(rx_frm),
    .par_err_clr_i(par_clr), .par_err_o(par_err), .rx_idle_o(rx_idle)
  );

  int total = 0;
  int bad   = 0;

  typedef struct packed {logic fe; logic [DW-1:0] d;} exp_t;
  exp_t exp_q[$];
  exp_t mon_e;
  int   valid_cnt = 0;
  int   rx_run = 0;
  int   rx_cnt = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      valid_cnt++;
      if (exp_q.size() == 0) chk(1'b0, "R7", "unexpected byte", int'(rx_data), -1);
      else begin
        mon_e = exp_q.pop_front();
        chk(rx_data == mon_e.d && rx_frm == mon_e.fe, "R7", "rx byte/frame flag",
            int'({rx_frm, rx_data}), int'({mon_e.fe, mon_e.d}));
      end
    end
  end

  // length of the last low run of rx_idle
  always @(negedge clk) begin
    if (!rst_n) rx_cnt = 0;
    else if (!rx_idle) rx_cnt++;
    else begin
      if (rx_cnt != 0) rx_run = rx_cnt;
      rx_cnt = 0;
    end
  end

  task automatic send(input logic [DW-1:0] b, input bit dis_mid);
    int f, j, nb, n;
    bit stat_bad;
    logic [11:0] bits, expb;
    f = C * (1 + 8 + (par_en ? 1 : 0) + (stop2 ? 2 : 1));
    expb = '0;
    for (int k = 0; k < 8; k++) expb[k+1] = b[k];
    n = 9;
    if (par_en) begin expb[9] = (^b) ^ par_odd; n = 10; end
    expb[n] = 1'b1;
    if (stop2) expb[n+1] = 1'b1;
    bits = '0;
    rx_run = 0;
    while (!tx_ready) @(negedge clk);
    tx_data  = b;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    if (loop_sel) exp_q.push_back('{fe: 1'b0, d: b});
    j = 0; nb = 0; stat_bad = 0;
    while (!tx_idle && j < 2000) begin
      if (j % C == C / 2 && nb < 12) begin bits[nb] = txd; nb++; end
      if (tx_dis_stat) stat_bad = 1;
      if (dis_mid && j == 3 * C) tx_dis = 1'b1;
      j++;
      @(negedge clk);
    end
    chk(j == f, "R5", "tx_idle low cycles", j, f);
    chk(j == f, "R3", "frame length for stop setting", j, f);
    chk(bits == expb, "R2", "serial bit slots", int'(bits), int'(expb));
    if (par_en) chk(bits[9] == expb[9], "R4", "parity bit", int'(bits[9]), int'(expb[9]));
    chk(!stat_bad, "R10", "disable status during frame", int'(stat_bad), 0);
    if (dis_mid) begin
      chk(!tx_dis_stat, "R10", "status at idle edge", int'(tx_dis_stat), 0);
      @(negedge clk);
      chk(tx_dis_stat, "R10", "status one clock after idle", int'(tx_dis_stat), 1);
      chk(!tx_ready, "R9", "ready while disabled", int'(tx_ready), 0);
    end
    if (loop_sel) begin
      repeat (4) @(negedge clk);
      chk(rx_run == f, "R6", "rx_idle low cycles", rx_run, f);
    end
  endtask

  task automatic rx_raw(input logic [DW-1:0] b, input logic pbit, input logic stopv);
    exp_q.push_back('{fe: !stopv, d: b});
    rx_drv = 1'b0;
    repeat (C) @(negedge clk);
    for (int i = 0; i < DW; i++) begin
      rx_drv = b[i];
      repeat (C) @(negedge clk);
    end
    if (par_en) begin
      rx_drv = pbit;
      repeat (C) @(negedge clk);
    end
    rx_drv = stopv;
    repeat (C) @(negedge clk);
    rx_drv = 1'b1;
    repeat (C + 6) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int vc;
    rst_n = 1'b0; stop2 = 0; par_en = 0; par_odd = 0; tx_dis = 0; tx_valid = 0;
    tx_data = '0; par_clr = 0; loop_sel = 1; rx_drv = 1;
    repeat (3) @(negedge clk);
    chk(txd && tx_idle && rx_idle && tx_ready, "R1", "idle outputs in reset",
        int'({txd, tx_idle, rx_idle, tx_ready}), 15);
    chk(!tx_dis_stat && !par_err && !rx_valid, "R1", "flags in reset",
        int'({tx_dis_stat, par_err, rx_valid}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // no parity, one stop
    send(8'hA5, 0);
    send(8'h01, 0);
    // no parity, two stops
    stop2 = 1;
    send(8'h3C, 0);
    // even parity, one stop
    stop2 = 0; par_en = 1; par_odd = 0;
    send(8'h7F, 0);
    // odd parity, two stops
    stop2 = 1; par_odd = 1;
    send(8'h00, 0);

    // graceful disable mid-frame
    stop2 = 0; par_en = 0; par_odd = 0;
    send(8'hC3, 1);
    tx_data = 8'h55; tx_valid = 1;
    repeat (C) @(negedge clk);
    chk(txd && tx_idle, "R9", "offer while disabled ignored", int'({txd, tx_idle}), 3);
    tx_valid = 0;
    @(negedge clk);
    tx_dis = 0;
    @(negedge clk);
    chk(!tx_dis_stat, "R10", "status cleared after enable", int'(tx_dis_stat), 0);
    chk(tx_ready, "R9", "ready after enable", int'(tx_ready), 1);
    repeat (2 * C) @(negedge clk);

    // receiver fault injection
    loop_sel = 0; rx_drv = 1;
    rx_raw(8'h96, 1'b0, 1'b0);
    rx_raw(8'h5A, 1'b0, 1'b1);

    // glitch shorter than half a bit
    vc = valid_cnt;
    rx_run = 0;
    rx_drv = 0;
    repeat (2) @(negedge clk);
    rx_drv = 1;
    repeat (3 * C) @(negedge clk);
    chk(valid_cnt == vc, "R11", "no byte from glitch", valid_cnt - vc, 0);
    chk(rx_idle && rx_run == C / 2, "R11", "half-bit busy window", rx_run, C / 2);

    // parity error detection
    par_en = 1; par_odd = 0;
    rx_raw(8'h35, 1'b0, 1'b1);
    chk(!par_err, "R8", "good parity no flag", int'(par_err), 0);
    rx_raw(8'h35, 1'b1, 1'b1);
    chk(par_err, "R8", "bad parity sets flag", int'(par_err), 1);
    repeat (5) @(negedge clk);
    chk(par_err, "R8", "flag sticky", int'(par_err), 1);
    par_clr = 1;
    @(negedge clk);
    par_clr = 0;
    @(negedge clk);
    chk(!par_err, "R8", "flag cleared", int'(par_err), 0);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R7", "all expected bytes seen", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule